// File: doc/BRIEF.md
# Exclusive Two-Level Line Swap Controller

This block manages a small first-level cache and a larger second-level cache that never hold the same line at the same time. A request that hits in the first level is answered on the next cycle and leaves the second level alone. A request that misses the first level but hits the second level starts a swap: the line now in the first-level slot is copied into a one-line victim buffer, the requested line is installed in the first level while its second-level slot is cleared in the same cycle, and the buffered victim is then written into that cleared slot. Unique storage therefore equals the first-level line count plus the second-level line count.

When both levels miss, the controller issues a line request to memory and holds it until the line arrives. The line is written into the second level, into an empty way if one exists and otherwise over the least-recently-used way. The old line in that way is discarded, because no dirty data is tracked. The normal swap then lifts the line into the first level. While a swap or a fill is running the controller refuses new requests.

The first level is direct-mapped. The second level is two-way set-associative and has no more sets than the first level. The requested line and its first-level victim therefore always map to the same second-level set. The caches are read-only, and line data comes only from memory.

Top module: `xsw_top`

## Requirements
- R1: While reset is held and after it is released, `req_ready_o` is 1 and `resp_valid_o` and `mem_req_o` are 0. Both levels start empty, so the first access to any line goes to memory.
- R2: A request that hits the first level is answered in the cycle after acceptance with `resp_src_o` = 0 and the line data. `req_ready_o` stays 1 and no memory request is made. The response lasts one cycle unless another first-level hit follows.
- R3: A request that misses the first level and hits the second level is answered two cycles after acceptance with `resp_src_o` = 1. `req_ready_o` is 0 for exactly three cycles after acceptance.
- R4: After a second-level hit, the requested line is in the first level and the earlier first-level occupant of that index is in the second level. A later access to that occupant is a second-level hit and does not go to memory.
- R5: On a miss in both levels, `mem_req_o` is 1 from the cycle after acceptance until the cycle in which `mem_valid_i` is sampled, and `mem_addr_o` holds the request address throughout. The response, with `resp_src_o` = 2 and the memory data, comes two cycles after the fill edge. `req_ready_o` returns one cycle after that.
- R6: A memory fill goes to way 0 if it is empty, otherwise to way 1 if it is empty, otherwise to the least-recently-used way, whose line is discarded. After a swap, the way that received a victim becomes most recently used. If there was no victim, the cleared way becomes the least-recently-used way.
- R7: No line address is valid in both levels at the same time.
- R8: While `req_ready_o` is 0, `req_valid_i` has no effect. While no memory request is pending, `mem_valid_i` has no effect.
- R9: With `L2_SETS` no larger than `L1_SETS`, L1_SETS + 2·L2_SETS distinct lines can be resident together. Re-accessing all of them makes no memory request.
- R10: A first-level hit leaves the contents of the second level and its recency state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Line address of the request |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle if valid |
| resp_valid_o | output | 1 | Response valid for one cycle |
| resp_data_o | output | DATA_W | Line data of the response |
| resp_src_o | output | 2 | Where the line was found: 0 first level, 1 second level, 2 memory |
| mem_req_o | output | 1 | Memory line request pending |
| mem_addr_o | output | ADDR_W | Line address requested from memory |
| mem_valid_i | input | 1 | Memory line data valid |
| mem_data_i | input | DATA_W | Memory line data |

## Verification
The cycle that installs a line in the first level is also the cycle that clears its second-level slot. Two swaps must also never overlap, or a stale request or stray memory beat would be taken mid-swap. The bench therefore keeps `req_valid_i` high with an unrelated address during every swap, and pulses `mem_valid_i` with garbage data while a second-level swap runs. A behavioural model of both levels predicts, for every request, where the line is found and the exact cycle of each output change. The checker tests on every cycle that no address is valid in both levels, so a split or overlapping exchange shows up either as a duplicate or as a later source mismatch.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM,
    ST_GRAB,
    ST_LIFT,
    ST_SINK
  } xsw_state_e;

  localparam logic [1:0] SRC_L1  = 2'd0;
  localparam logic [1:0] SRC_L2  = 2'd1;
  localparam logic [1:0] SRC_MEM = 2'd2;
endpackage

// File: rtl/xsw_l1.sv
module xsw_l1 #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [ADDR_W-1:0]                  lk_addr_i,
  output logic                               hit_o,
  output logic [DATA_W-1:0]                  data_o,
  output logic                               occ_valid_o,
  output logic [ADDR_W-1:0]                  occ_addr_o,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  output logic [SETS-1:0]                    valid_o,
  output logic [SETS-1:0][ADDR_W-$clog2(SETS)-1:0] tag_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]             valid_q;
  logic [SETS-1:0][TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0]           data_q [SETS];
  logic [IDX_W-1:0]            lk_idx, wr_idx;

  assign lk_idx = lk_addr_i[IDX_W-1:0];
  assign wr_idx = wr_addr_i[IDX_W-1:0];

  assign hit_o       = valid_q[lk_idx] && (tag_q[lk_idx] == lk_addr_i[ADDR_W-1:IDX_W]);
  assign data_o      = data_q[lk_idx];
  assign occ_valid_o = valid_q[lk_idx];
  assign occ_addr_o  = {tag_q[lk_idx], lk_idx};
  assign valid_o     = valid_q;
  assign tag_o       = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_addr_i[ADDR_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_idx] <= wr_data_i;
  end
endmodule

// File: rtl/xsw_l2.sv
module xsw_l2 #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 4
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [ADDR_W-1:0]                             lk_addr_i,
  output logic                                          hit_o,
  output logic                                          hit_way_o,
  output logic [DATA_W-1:0]                             hit_data_o,
  output logic                                          fill_way_o,
  input  logic                                          wr_en_i,
  input  logic                                          wr_way_i,
  input  logic                                          wr_valid_i,
  input  logic [ADDR_W-1:0]                             wr_addr_i,
  input  logic [DATA_W-1:0]                             wr_data_i,
  input  logic                                          lru_we_i,
  input  logic                                          lru_val_i,
  output logic [SETS-1:0][1:0]                          valid_o,
  output logic [SETS-1:0][1:0][ADDR_W-$clog2(SETS)-1:0] tag_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAYS  = 2;

  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0]                      lru_q;
  logic [DATA_W-1:0]                    data_q [SETS][WAYS];
  logic [IDX_W-1:0]                     set;
  logic [WAYS-1:0]                      way_hit;

  // every access in one operation targets the set of the lookup address
  assign set = lk_addr_i[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = valid_q[set][w] && (tag_q[set][w] == lk_addr_i[ADDR_W-1:IDX_W]);
  end

  assign hit_o      = |way_hit;
  assign hit_way_o  = way_hit[1];
  assign hit_data_o = data_q[set][way_hit[1]];
  assign fill_way_o = !valid_q[set][0] ? 1'b0 :
                      !valid_q[set][1] ? 1'b1 : lru_q[set];
  assign valid_o    = valid_q;
  assign tag_o      = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      lru_q   <= '0;
    end else begin
      if (wr_en_i) begin
        valid_q[set][wr_way_i] <= wr_valid_i;
        tag_q[set][wr_way_i]   <= wr_addr_i[ADDR_W-1:IDX_W];
      end
      if (lru_we_i) lru_q[set] <= lru_val_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_valid_i) data_q[set][wr_way_i] <= wr_data_i;
  end
endmodule

// File: rtl/xsw_seq.sv
module xsw_seq
  import xsw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic [1:0]        resp_src_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              l1_hit_i,
  input  logic [DATA_W-1:0] l1_data_i,
  input  logic              l1_occ_valid_i,
  input  logic [ADDR_W-1:0] l1_occ_addr_i,
  output logic              l1_we_o,
  output logic [ADDR_W-1:0] l1_wr_addr_o,
  output logic [DATA_W-1:0] l1_wr_data_o,
  input  logic              l2_hit_i,
  input  logic              l2_hit_way_i,
  input  logic [DATA_W-1:0] l2_hit_data_i,
  input  logic              l2_fill_way_i,
  output logic              l2_we_o,
  output logic              l2_way_o,
  output logic              l2_wr_valid_o,
  output logic [ADDR_W-1:0] l2_wr_addr_o,
  output logic [DATA_W-1:0] l2_wr_data_o,
  output logic              l2_lru_we_o,
  output logic              l2_lru_val_o
);
  xsw_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              way_q, from_mem_q;
  logic              buf_valid_q;
  logic [ADDR_W-1:0] buf_addr_q;
  logic [DATA_W-1:0] buf_data_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_data_q;
  logic [1:0]        resp_src_q;
  logic              accept;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign accept       = req_valid_i && req_ready_o;
  assign lk_addr_o    = req_ready_o ? req_addr_i : addr_q;
  assign mem_req_o    = (state_q == ST_MEM);
  assign mem_addr_o   = addr_q;
  assign resp_valid_o = resp_valid_q;
  assign resp_data_o  = resp_data_q;
  assign resp_src_o   = resp_src_q;

  // requested line enters the first level in the same cycle its second-level slot clears
  assign l1_we_o      = (state_q == ST_LIFT);
  assign l1_wr_addr_o = addr_q;
  assign l1_wr_data_o = l2_hit_data_i;

  always_comb begin
    l2_we_o       = 1'b0;
    l2_way_o      = 1'b0;
    l2_wr_valid_o = 1'b0;
    l2_wr_addr_o  = addr_q;
    l2_wr_data_o  = mem_data_i;
    l2_lru_we_o   = 1'b0;
    l2_lru_val_o  = 1'b0;
    unique case (state_q)
      ST_MEM: begin
        l2_we_o       = mem_valid_i;
        l2_way_o      = l2_fill_way_i;
        l2_wr_valid_o = 1'b1;
      end
      ST_LIFT: begin
        l2_we_o  = 1'b1;
        l2_way_o = l2_hit_way_i;
      end
      ST_SINK: begin
        l2_we_o       = 1'b1;
        l2_way_o      = way_q;
        l2_wr_valid_o = buf_valid_q;
        l2_wr_addr_o  = buf_addr_q;
        l2_wr_data_o  = buf_data_q;
        l2_lru_we_o   = 1'b1;
        l2_lru_val_o  = buf_valid_q ? ~way_q : way_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      way_q        <= 1'b0;
      from_mem_q   <= 1'b0;
      buf_valid_q  <= 1'b0;
      buf_addr_q   <= '0;
      buf_data_q   <= '0;
      resp_valid_q <= 1'b0;
      resp_data_q  <= '0;
      resp_src_q   <= SRC_L1;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q     <= req_addr_i;
          from_mem_q <= !l2_hit_i;
          if (l1_hit_i) begin
            resp_valid_q <= 1'b1;
            resp_data_q  <= l1_data_i;
            resp_src_q   <= SRC_L1;
          end else begin
            state_q <= l2_hit_i ? ST_GRAB : ST_MEM;
          end
        end
        ST_MEM: if (mem_valid_i) state_q <= ST_GRAB;
        ST_GRAB: begin
          buf_valid_q <= l1_occ_valid_i;
          buf_addr_q  <= l1_occ_addr_i;
          buf_data_q  <= l1_data_i;
          state_q     <= ST_LIFT;
        end
        ST_LIFT: begin
          way_q        <= l2_hit_way_i;
          resp_valid_q <= 1'b1;
          resp_data_q  <= l2_hit_data_i;
          resp_src_q   <= from_mem_q ? SRC_MEM : SRC_L2;
          state_q      <= ST_SINK;
        end
        ST_SINK: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xsw_top.sv
module xsw_top #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int L1_SETS = 8,
  parameter int L2_SETS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic [1:0]        resp_src_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int L1_TAG_W = ADDR_W - $clog2(L1_SETS);
  localparam int L2_TAG_W = ADDR_W - $clog2(L2_SETS);

  logic [ADDR_W-1:0] lk_addr;
  logic              l1_hit, l1_occ_valid, l1_we;
  logic [DATA_W-1:0] l1_data, l1_wr_data;
  logic [ADDR_W-1:0] l1_occ_addr, l1_wr_addr;
  logic              l2_hit, l2_hit_way, l2_fill_way, l2_we, l2_way, l2_wr_valid;
  logic              l2_lru_we, l2_lru_val;
  logic [DATA_W-1:0] l2_hit_data, l2_wr_data;
  logic [ADDR_W-1:0] l2_wr_addr;

  logic [L1_SETS-1:0]                     l1_valid;
  logic [L1_SETS-1:0][L1_TAG_W-1:0]       l1_tag;
  logic [L2_SETS-1:0][1:0]                l2_valid;
  logic [L2_SETS-1:0][1:0][L2_TAG_W-1:0]  l2_tag;

  xsw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .resp_valid_o, .resp_data_o, .resp_src_o,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i,
    .lk_addr_o      (lk_addr),
    .l1_hit_i       (l1_hit),
    .l1_data_i      (l1_data),
    .l1_occ_valid_i (l1_occ_valid),
    .l1_occ_addr_i  (l1_occ_addr),
    .l1_we_o        (l1_we),
    .l1_wr_addr_o   (l1_wr_addr),
    .l1_wr_data_o   (l1_wr_data),
    .l2_hit_i       (l2_hit),
    .l2_hit_way_i   (l2_hit_way),
    .l2_hit_data_i  (l2_hit_data),
    .l2_fill_way_i  (l2_fill_way),
    .l2_we_o        (l2_we),
    .l2_way_o       (l2_way),
    .l2_wr_valid_o  (l2_wr_valid),
    .l2_wr_addr_o   (l2_wr_addr),
    .l2_wr_data_o   (l2_wr_data),
    .l2_lru_we_o    (l2_lru_we),
    .l2_lru_val_o   (l2_lru_val)
  );

  xsw_l1 #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(L1_SETS)) u_l1 (
    .clk_i, .rst_ni,
    .lk_addr_i   (lk_addr),
    .hit_o       (l1_hit),
    .data_o      (l1_data),
    .occ_valid_o (l1_occ_valid),
    .occ_addr_o  (l1_occ_addr),
    .wr_en_i     (l1_we),
    .wr_addr_i   (l1_wr_addr),
    .wr_data_i   (l1_wr_data),
    .valid_o     (l1_valid),
    .tag_o       (l1_tag)
  );

  xsw_l2 #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(L2_SETS)) u_l2 (
    .clk_i, .rst_ni,
    .lk_addr_i  (lk_addr),
    .hit_o      (l2_hit),
    .hit_way_o  (l2_hit_way),
    .hit_data_o (l2_hit_data),
    .fill_way_o (l2_fill_way),
    .wr_en_i    (l2_we),
    .wr_way_i   (l2_way),
    .wr_valid_i (l2_wr_valid),
    .wr_addr_i  (l2_wr_addr),
    .wr_data_i  (l2_wr_data),
    .lru_we_i   (l2_lru_we),
    .lru_val_i  (l2_lru_val),
    .valid_o    (l2_valid),
    .tag_o      (l2_tag)
  );
endmodule

// File: rtl/xsw_chk.sv
module xsw_chk
  import xsw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int L1_SETS = 8,
  parameter int L2_SETS = 4
) (
  input logic                                                  clk_i,
  input logic                                                  rst_ni,
  input logic                                                  req_valid_i,
  input logic                                                  req_ready_o,
  input logic                                                  resp_valid_o,
  input logic [1:0]                                            resp_src_o,
  input logic                                                  mem_req_o,
  input logic [ADDR_W-1:0]                                     mem_addr_o,
  input logic                                                  mem_valid_i,
  input logic [L1_SETS-1:0]                                    l1_valid,
  input logic [L1_SETS-1:0][ADDR_W-$clog2(L1_SETS)-1:0]        l1_tag,
  input logic [L2_SETS-1:0][1:0]                               l2_valid,
  input logic [L2_SETS-1:0][1:0][ADDR_W-$clog2(L2_SETS)-1:0]   l2_tag
);
  localparam int I1_W = $clog2(L1_SETS);
  localparam int I2_W = $clog2(L2_SETS);

  for (genvar i = 0; i < L1_SETS; i++) begin : g_l1
    localparam int S = i % L2_SETS;
    for (genvar w = 0; w < 2; w++) begin : g_way
      logic [ADDR_W-1:0] a1, a2;
      assign a1 = {l1_tag[i], I1_W'(i)};
      assign a2 = {l2_tag[S][w], I2_W'(S)};
      // R7
      no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(l1_valid[i] && l2_valid[S][w] && (a1 == a2)));
    end
  end

  // R2
  l1_resp_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_src_o == SRC_L1) |-> $past(req_valid_i && req_ready_o));

  // R3
  slow_resp_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_src_o != SRC_L1) |-> !req_ready_o);

  // R5
  mem_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));

  // R5
  fill_ends_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> !mem_req_o);

  // R8
  mem_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

bind xsw_top xsw_chk #(
  .ADDR_W (ADDR_W),
  .L1_SETS(L1_SETS),
  .L2_SETS(L2_SETS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .resp_src_o   (resp_src_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_valid_i  (mem_valid_i),
  .l1_valid     (l1_valid),
  .l1_tag       (l1_tag),
  .l2_valid     (l2_valid),
  .l2_tag       (l2_tag)
);

// File: tb/xsw_top_tb_top.sv
module xsw_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int L1_SETS = 8;
  localparam int L2_SETS = 4;
  localparam int K_L1 = 0, K_L2 = 1, K_MEM = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              req_ready_o, resp_valid_o, mem_req_o;
  logic [DATA_W-1:0] resp_data_o;
  logic [1:0]        resp_src_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_valid_i = 1'b0;
  logic [DATA_W-1:0] mem_data_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int l1m [L1_SETS];
  int l2m [L2_SETS][2];
  bit lrum [L2_SETS];

  always #2.5 clk = ~clk;

  xsw_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .L1_SETS(L1_SETS), .L2_SETS(L2_SETS)) dut_i (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .resp_valid_o, .resp_data_o, .resp_src_o,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i
  );

  function automatic logic [DATA_W-1:0] mf(int a);
    return (32'(a) * 32'h0100_0193) ^ 32'hA5C3_0F1E;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < L1_SETS; i++) l1m[i] = -1;
    for (int s = 0; s < L2_SETS; s++) begin
      l2m[s][0] = -1; l2m[s][1] = -1; lrum[s] = 0;
    end
  endtask

  // behavioural prediction of where a line is found, updating both levels
  task automatic classify(int a, output int kind);
    int idx, set, w, v;
    idx = a % L1_SETS;
    set = a % L2_SETS;
    if (l1m[idx] == a) begin
      kind = K_L1;
      return;
    end
    if (l2m[set][0] == a) begin kind = K_L2; w = 0; end
    else if (l2m[set][1] == a) begin kind = K_L2; w = 1; end
    else begin
      kind = K_MEM;
      if (l2m[set][0] < 0) w = 0;
      else if (l2m[set][1] < 0) w = 1;
      else w = int'(lrum[set]);
      l2m[set][w] = a;
    end
    v = l1m[idx];
    l1m[idx] = a;
    l2m[set][w] = v;
    lrum[set] = (v >= 0) ? bit'(1 - w) : bit'(w);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    mem_valid_i = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready_o, 1);
    chk("R1 resp in reset", resp_valid_o, 0);
    chk("R1 mem_req in reset", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready_o, 1);
    chk("R1 resp after reset", resp_valid_o, 0);
  endtask

  task automatic req(int a, int lat, string tag, output int kind);
    @(negedge clk);
    chk({tag, " R8 ready before request"}, req_ready_o, 1);
    chk({tag, " R2 resp idle"}, resp_valid_o, 0);
    classify(a, kind);
    req_valid_i = 1'b1;
    req_addr_i  = ADDR_W'(a);
    @(negedge clk);
    if (kind == K_L1) begin
      chk({tag, " R2 R10 resp"}, resp_valid_o, 1);
      chk({tag, " R2 src"}, resp_src_o, 0);
      chk({tag, " R2 data"}, resp_data_o, mf(a));
      chk({tag, " R2 ready"}, req_ready_o, 1);
      chk({tag, " R2 no mem"}, mem_req_o, 0);
      req_valid_i = 1'b0;
    end else if (kind == K_L2) begin
      req_addr_i  = ADDR_W'(a ^ 'h5A);
      mem_valid_i = 1'b1;
      mem_data_i  = 32'hDEAD_BEEF;
      for (int c = 0; c < 2; c++) begin
        chk({tag, " R3 R8 busy"}, req_ready_o, 0);
        chk({tag, " R3 no early resp"}, resp_valid_o, 0);
        chk({tag, " R4 no mem"}, mem_req_o, 0);
        @(negedge clk);
      end
      chk({tag, " R3 R4 R7 resp"}, resp_valid_o, 1);
      chk({tag, " R3 R4 src"}, resp_src_o, 1);
      chk({tag, " R3 R8 data"}, resp_data_o, mf(a));
      chk({tag, " R3 busy"}, req_ready_o, 0);
      req_valid_i = 1'b0;
      mem_valid_i = 1'b0;
      @(negedge clk);
      chk({tag, " R3 ready back"}, req_ready_o, 1);
    end else begin
      chk({tag, " R5 mem_req"}, mem_req_o, 1);
      chk({tag, " R5 mem_addr"}, mem_addr_o, a);
      chk({tag, " R5 busy"}, req_ready_o, 0);
      req_addr_i = ADDR_W'(a ^ 'h5A);
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        chk({tag, " R5 mem_req held"}, mem_req_o, 1);
        chk({tag, " R5 mem_addr held"}, mem_addr_o, a);
      end
      mem_valid_i = 1'b1;
      mem_data_i  = mf(a);
      @(negedge clk);
      chk({tag, " R5 mem_req drop"}, mem_req_o, 0);
      mem_valid_i = 1'b0;
      mem_data_i  = 32'h0BAD_F00D;
      @(negedge clk);
      chk({tag, " R5 no early resp"}, resp_valid_o, 0);
      @(negedge clk);
      chk({tag, " R5 R6 resp"}, resp_valid_o, 1);
      chk({tag, " R5 R6 src"}, resp_src_o, 2);
      chk({tag, " R5 data"}, resp_data_o, mf(a));
      chk({tag, " R5 busy"}, req_ready_o, 0);
      req_valid_i = 1'b0;
      @(negedge clk);
      chk({tag, " R5 ready back"}, req_ready_o, 1);
    end
  endtask

  initial begin
    int k;
    int seed;
    do_reset();
    // directed swap walk
    req('h10, 1, "cold", k);
    chk("R1 cold line from memory", k, K_MEM);
    req('h10, 0, "repeat", k);
    req('h18, 0, "conflict", k);
    req('h10, 0, "swap back", k);
    chk("R4 victim found in L2", k, K_L2);
    req('h18, 2, "swap again", k);
    chk("R4 second victim found in L2", k, K_L2);
    // capacity
    do_reset();
    for (int i = 0; i < L1_SETS; i++) req('h20 + i, i % 3, "cap fill a", k);
    for (int i = 0; i < L1_SETS; i++) req('h30 + i, 1, "cap fill b", k);
    for (int i = 0; i < L1_SETS; i++) begin
      req('h20 + i, 0, "cap reread a", k);
      chk("R9 resident line a", int'(k != K_MEM), 1);
      req('h30 + i, 0, "cap reread b", k);
      chk("R9 resident line b", int'(k != K_MEM), 1);
    end
    req('h40, 0, "R6 drop lru", k);
    req('h40, 0, "R10 L1 hit", k);
    req('h48, 1, "R6 second drop", k);
    // pseudo-random mix
    seed = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      seed = seed * 1103515245 + 12345;
      req((seed >>> 16) & 'h7FFF % 1 + ((seed >>> 16) & 'h7FFF) % 40, (seed >>> 8) & 3, "mix", k);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule